// File: doc/BRIEF.md
# Universal Bidirectional Shift Register

A storage register of parameterised width (four bits by default) that performs one of four operations on every rising clock edge, chosen by a 2-bit mode code. It can keep its contents, move them one place toward the low end, move them one place toward the high end, or take a new word from a parallel data input. Each shift direction has its own serial input. The bit at each end of the register is always visible on a serial output, and the whole word is always visible on a parallel output.

An active-low clear input empties the register at once, whatever the clock or the mode is doing. The clear is released through a two-stage synchroniser, so the register starts following the mode code again a fixed number of edges after the clear input goes high. Loads are enabled and disabled only through the mode code. The clock always runs freely.

Typical uses are converting between serial and parallel data, scaling a value by a power of two, and delaying a bit stream by a chosen number of cycles.

Top module: `ushreg`

## Requirements
- R1: With mode_sel = 2'b00 (hold), q keeps its value across the rising edge.
- R2: With mode_sel = 2'b01 (shift right), each bit q[i] takes the old q[i+1] and q[W-1] takes shr_in. Bit W-1 is the left end and bit 0 is the right end.
- R3: With mode_sel = 2'b10 (shift left), each bit q[i] takes the old q[i-1] and q[0] takes shl_in.
- R4: With mode_sel = 2'b11 (load), q takes the value of din on the rising edge.
- R5: While clear_n is low, q is all zeros. q is forced to zero as soon as clear_n falls, without waiting for a clock edge, and the mode has no effect.
- R6: After clear_n rises, q stays zero through the next two rising edges. The third rising edge is the first one that applies mode_sel.
- R7: so_right always equals q[0] and so_left always equals q[W-1]. After a right shift, so_right therefore shows the old q[1]. After a left shift, so_left shows the old q[W-2].
- R8: Inputs that the selected mode does not use have no effect. din is ignored unless the mode is 2'b11. shr_in is ignored unless the mode is 2'b01. shl_in is ignored unless the mode is 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, rising edge active |
| clear_n | input | 1 | Asynchronous active-low clear, released synchronously |
| mode_sel | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 parallel load |
| shr_in | input | 1 | Serial input that enters the left end during a right shift |
| shl_in | input | 1 | Serial input that enters the right end during a left shift |
| din | input | W | Parallel data input |
| q | output | W | Parallel output of the whole register |
| so_right | output | 1 | Right-end serial output (q[0]) |
| so_left | output | 1 | Left-end serial output (q[W-1]) |

## Verification
The bench builds the register with the default width of four bits. At that width every mode can be exercised from a known word in a few edges, and a single bit can be walked across the whole register and out of either end within four shifts. The stimulus drives unused serial and parallel inputs to values that would show up if they leaked into q. The clear is dropped in the middle of a clock cycle to show that it acts without a clock edge, and the edge count after release is checked exactly.

// File: rtl/ushreg_pkg.sv
package ushreg_pkg;

  // mode_sel encoding: {S0, S1}
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/ushreg_rst_sync.sv
module ushreg_rst_sync #(
  parameter int unsigned STAGES = ushreg_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

  // R5: the synchronised clear is low whenever the raw clear is low
  assert_sync_follows_R5: assert property (@(posedge clk)
    !arst_n |-> !rst_sync_n);

endmodule

// File: rtl/ushreg_stage.sv
module ushreg_stage
  import ushreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode,
  input  logic  from_left,
  input  logic  from_right,
  input  logic  din_bit,
  output logic  q
);

  logic q_d;

  always_comb begin
    unique case (mode)
      MODE_HOLD: q_d = q;
      MODE_SHR:  q_d = from_left;
      MODE_SHL:  q_d = from_right;
      MODE_LOAD: q_d = din_bit;
      default:   q_d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

endmodule

// File: rtl/ushreg.sv
module ushreg
  import ushreg_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic [1:0]   mode_sel,
  input  logic         shr_in,
  input  logic         shl_in,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         so_right,
  output logic         so_left
);

  localparam int unsigned MSB = W - 1;

  logic  clr_sync_n;
  mode_e mode;

  assign mode = mode_e'(mode_sel);

  ushreg_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .arst_n    (clear_n),
    .rst_sync_n(clr_sync_n)
  );

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic left_nb;
    logic right_nb;
    if (i == MSB) begin : g_top
      assign left_nb = shr_in;
    end else begin : g_mid_l
      assign left_nb = q[i+1];
    end
    if (i == 0) begin : g_bot
      assign right_nb = shl_in;
    end else begin : g_mid_r
      assign right_nb = q[i-1];
    end
    ushreg_stage u_bit (
      .clk       (clk),
      .rst_n     (clr_sync_n),
      .mode      (mode),
      .from_left (left_nb),
      .from_right(right_nb),
      .din_bit   (din[i]),
      .q         (q[i])
    );
  end

  assign so_right = q[0];
  assign so_left  = q[MSB];

  // R1
  assert_hold_R1: assert property (@(posedge clk) disable iff (!clr_sync_n)
    (mode_sel == 2'b00) |=> $stable(q));
  // R2
  assert_shr_R2: assert property (@(posedge clk) disable iff (!clr_sync_n)
    (mode_sel == 2'b01) |=> (q == {$past(shr_in), $past(q[MSB:1])}));
  // R3
  assert_shl_R3: assert property (@(posedge clk) disable iff (!clr_sync_n)
    (mode_sel == 2'b10) |=> (q == {$past(q[MSB-1:0]), $past(shl_in)}));
  // R4
  assert_load_R4: assert property (@(posedge clk) disable iff (!clr_sync_n)
    (mode_sel == 2'b11) |=> (q == $past(din)));
  // R5
  assert_clear_R5: assert property (@(posedge clk)
    !clr_sync_n |-> (q == '0));
  // R7
  assert_sout_right_R7: assert property (@(posedge clk) disable iff (!clr_sync_n)
    (mode_sel == 2'b01) |=> (so_right == $past(q[1])));
  assert_sout_left_R7: assert property (@(posedge clk) disable iff (!clr_sync_n)
    (mode_sel == 2'b10) |=> (so_left == $past(q[MSB-1])));

endmodule

// File: tb/ushreg_tb.sv
module ushreg_tb;

  localparam int unsigned W = 4;
  localparam int unsigned NV = 16;

  // vector: [11:10] mode, [9] shr_in, [8] shl_in, [7:4] din, [3:0] expected q
  localparam logic [11:0] VEC [NV] = '{
    12'b11_0_0_1011_1011,
    12'b00_0_0_0000_1011,
    12'b01_0_0_0000_0101,
    12'b01_1_0_0000_1010,
    12'b10_0_1_0000_0101,
    12'b10_0_0_0000_1010,
    12'b10_0_1_0000_0101,
    12'b11_0_0_1111_1111,
    12'b01_0_0_0000_0111,
    12'b01_0_0_0000_0011,
    12'b01_0_0_0000_0001,
    12'b01_0_0_0000_0000,
    12'b10_0_1_0000_0001,
    12'b10_0_1_0000_0011,
    12'b00_1_1_1100_0011,
    12'b11_0_0_0110_0110
  };

  logic         clk;
  logic         clear_n;
  logic [1:0]   mode_sel;
  logic         shr_in;
  logic         shl_in;
  logic [W-1:0] din;
  logic [W-1:0] q;
  logic         so_right;
  logic         so_left;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  ushreg #(.W(W)) u_dut (
    .clk(clk), .clear_n(clear_n), .mode_sel(mode_sel), .shr_in(shr_in),
    .shl_in(shl_in), .din(din), .q(q), .so_right(so_right), .so_left(so_left)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [W-1:0] exp);
    chk(req, q, exp);
    chk({req, " R7 so_right"}, {{(W-1){1'b0}}, so_right}, {{(W-1){1'b0}}, exp[0]});
    chk({req, " R7 so_left"},  {{(W-1){1'b0}}, so_left},  {{(W-1){1'b0}}, exp[W-1]});
  endtask

  task automatic drive(input logic [1:0] m, input logic sr, input logic sl, input logic [W-1:0] d);
    mode_sel = m; shr_in = sr; shl_in = sl; din = d;
  endtask

  initial begin
    clear_n = 1'b0;
    drive(2'b11, 1'b1, 1'b1, 4'b1111);
    repeat (3) @(posedge clk);
    #1 chk_all("R5 clear at start", 4'b0000);

    // R6: release with load pending; two edges pass before it applies
    @(negedge clk);
    clear_n = 1'b1;
    drive(2'b11, 1'b0, 1'b0, 4'b0000);
    @(posedge clk); #1 chk("R6 edge 1 after release", q, 4'b0000);
    @(posedge clk); #1 chk("R6 edge 2 after release", q, 4'b0000);

    // vector walk, starting from q = 0000
    for (int i = 0; i < NV; i++) begin
      string req;
      @(negedge clk);
      drive(VEC[i][11:10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
      case (VEC[i][11:10])
        2'b00:   req = "R1 R8 hold";
        2'b01:   req = "R2 R8 shift right";
        2'b10:   req = "R3 R8 shift left";
        default: req = "R4 load";
      endcase
      @(posedge clk); #1 chk_all(req, VEC[i][3:0]);
    end

    // R5: clear dropped mid-cycle during shifting acts without an edge
    @(negedge clk);
    drive(2'b10, 1'b1, 1'b1, 4'b1010);
    @(posedge clk); #1 chk("R3 shift before clear", q, 4'b1101);
    #0.5 clear_n = 1'b0;
    #0.5 chk_all("R5 async clear mid-cycle", 4'b0000);
    drive(2'b11, 1'b0, 1'b0, 4'b1001);
    @(posedge clk); #1 chk("R5 load ignored while clear low", q, 4'b0000);
    @(negedge clk); clear_n = 1'b1;
    @(posedge clk); #1 chk("R6 edge 1 after mid-run release", q, 4'b0000);
    @(posedge clk); #1 chk("R6 edge 2 after mid-run release", q, 4'b0000);
    @(posedge clk); #1 chk_all("R6 edge 3 applies load", 4'b1001);

    // R8: shift right ignores din and shl_in
    @(negedge clk);
    drive(2'b01, 1'b0, 1'b1, 4'b1111);
    @(posedge clk); #1 chk_all("R2 R8 shift right ignores din/shl_in", 4'b0100);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule